// File: doc/BRIEF.md
# MII Receive Preamble and Length Checker

This block sits on a 4-bit MII receive path running in the core clock domain. Each clock cycle in which the receive-valid input is high carries one nibble. For every frame the block counts the preamble nibbles that come before the start-of-frame delimiter. It then counts the whole bytes that follow the delimiter until receive-valid falls. Both counts are compared with programmable lower and upper limits, and a failed comparison sets one of four sticky error flags.

Nibbles are packed into bytes, low nibble first. Each byte appears on a byte output with a one-cycle valid strobe. A 16-bit word output holds the two most recent bytes, and their order can be reversed. A strip option removes the preamble and the delimiter so that only frame content is forwarded. A one-cycle end-of-frame pulse marks the end of each frame that reached its data phase.

A small word-addressed register port holds the configuration bits, the two limit pairs and the error flags. Reads are combinational. Writes take effect at the clock edge.

Top module: `mii_rx_frame_guard`

## Requirements
- R1: After reset the registers read as follows. Address 0 (control) reads 0. Address 1 (preamble limits) reads 0x0E1: the minimum in bits [3:0] resets to 1 and the maximum in bits [8:4] resets to 14. Address 2 (frame limits) reads 0x05F1003F: the minimum in bits [15:0] resets to 63 and the maximum in bits [31:16] resets to 1521. Address 3 (error flags) reads 0.
- R2: A frame whose preamble count and byte count both lie inside their limits sets no error flag.
- R3: The delimiter is the byte 0xD5, which arrives as a 0x5 nibble followed by a 0xD nibble; preamble nibbles are 0x5. The preamble count is the number of nibbles received before the delimiter's 0x5 nibble. A count below the minimum sets error bit 0.
- R4: A preamble count above the maximum at the delimiter sets error bit 1.
- R5: If receive-valid falls before any delimiter and the number of nibbles received exceeds the maximum, error bit 1 is set.
- R6: Frame length is the number of whole bytes after the delimiter, evaluated when receive-valid falls. A length below the minimum sets error bit 2, and a length above the maximum sets error bit 3. A length equal to either limit sets neither bit.
- R7: Error flags stay set until 1 is written to their bit at address 3. Writing 0 leaves a flag unchanged, and clearing one bit leaves the others as they are.
- R8: With strip off (control bit 1 = 0), every nibble is forwarded, preamble and delimiter included, and bytes are assembled low nibble first.
- R9: With strip on (control bit 1 = 1), only the bytes after the delimiter are forwarded.
- R10: The word output holds the earlier byte in bits [7:0] and the later byte in bits [15:8]. With control bit 2 set, the two bytes trade places.
- R11: Exactly one end-of-frame pulse follows the fall of receive-valid for a frame that reached its data phase. A frame that never saw a delimiter produces none.
- R12: While control bit 0 (enable) is clear, no byte strobe, no end-of-frame pulse and no error flag is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| rx_dv | input | 1 | Receive-valid; one nibble per cycle while high |
| rx_nib | input | 4 | Receive nibble |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| out_byte | output | 8 | Assembled byte |
| out_byte_vld | output | 1 | One-cycle strobe for out_byte |
| out_word | output | 16 | Two most recent bytes, order selectable |
| out_eof | output | 1 | End-of-frame pulse |

## Verification
The assertions take for granted that receive-valid rises and falls only between frames, and that the configuration registers are not rewritten while a frame is in progress. The stimulus writes the limits and control bits only while the line is idle and leaves idle gaps of several cycles between frames. Every frame carries a whole number of bytes, so no odd trailing nibble reaches the byte packer.

// File: rtl/mrfg_pkg.sv
package mrfg_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA} trk_st_e;

   localparam int ERR_N         = 4;
   localparam int ERR_PRE_SHORT = 0;
   localparam int ERR_PRE_LONG  = 1;
   localparam int ERR_FRM_SHORT = 2;
   localparam int ERR_FRM_LONG  = 3;

   localparam logic [3:0] NIB_PRE = 4'h5;
   localparam logic [3:0] NIB_SFD = 4'hD;

   localparam int ADDR_CTL  = 0;
   localparam int ADDR_PLIM = 1;
   localparam int ADDR_FLIM = 2;
   localparam int ADDR_ERR  = 3;
endpackage

// File: rtl/mrfg_regs.sv
module mrfg_regs
   import mrfg_pkg::*;
#(
   parameter int DW          = 32,
   parameter int AW          = 2,
   parameter int PMIN_W      = 4,
   parameter int PMAX_W      = 5,
   parameter int LEN_W       = 16,
   parameter int PMIN_RST    = 1,
   parameter int PMAX_RST    = 14,
   parameter int LMIN_RST    = 63,
   parameter int LMAX_RST    = 1521
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [ERR_N-1:0]  err_set,
   output logic              en,
   output logic              strip,
   output logic              swap,
   output logic [PMIN_W-1:0] pre_min,
   output logic [PMAX_W-1:0] pre_max,
   output logic [LEN_W-1:0]  len_min,
   output logic [LEN_W-1:0]  len_max,
   output logic [ERR_N-1:0]  err_q
);
   localparam int HALF = DW / 2;

   if (LEN_W > HALF) begin : g_bad_len
      $error("LEN_W must fit in half a register word");
   end
   if (PMIN_W + PMAX_W > DW) begin : g_bad_pre
      $error("preamble limit fields do not fit");
   end

   logic sel_ctl, sel_plim, sel_flim, sel_err;
   assign sel_ctl  = wr_en && (addr == AW'(ADDR_CTL));
   assign sel_plim = wr_en && (addr == AW'(ADDR_PLIM));
   assign sel_flim = wr_en && (addr == AW'(ADDR_FLIM));
   assign sel_err  = wr_en && (addr == AW'(ADDR_ERR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         strip   <= 1'b0;
         swap    <= 1'b0;
         pre_min <= PMIN_W'(PMIN_RST);
         pre_max <= PMAX_W'(PMAX_RST);
         len_min <= LEN_W'(LMIN_RST);
         len_max <= LEN_W'(LMAX_RST);
      end else begin
         if (sel_ctl) begin
            en    <= wdata[0];
            strip <= wdata[1];
            swap  <= wdata[2];
         end
         if (sel_plim) begin
            pre_min <= wdata[PMIN_W-1:0];
            pre_max <= wdata[PMIN_W +: PMAX_W];
         end
         if (sel_flim) begin
            len_min <= wdata[LEN_W-1:0];
            len_max <= wdata[HALF +: LEN_W];
         end
      end
   end

   for (genvar i = 0; i < ERR_N; i++) begin : g_flag
      logic clr_hit;
      assign clr_hit = sel_err && wdata[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          err_q[i] <= 1'b0;
         else if (err_set[i]) err_q[i] <= 1'b1;
         else if (clr_hit)    err_q[i] <= 1'b0;
      end
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (err_q[i] && !clr_hit) |=> err_q[i]); // R7
   end

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(ADDR_CTL):  rdata[2:0] = {swap, strip, en};
         AW'(ADDR_PLIM): begin
            rdata[PMIN_W-1:0]       = pre_min;
            rdata[PMIN_W +: PMAX_W] = pre_max;
         end
         AW'(ADDR_FLIM): begin
            rdata[LEN_W-1:0]     = len_min;
            rdata[HALF +: LEN_W] = len_max;
         end
         AW'(ADDR_ERR):  rdata[ERR_N-1:0] = err_q;
         default:        rdata = '0;
      endcase
   end
endmodule

// File: rtl/mrfg_track.sv
module mrfg_track
   import mrfg_pkg::*;
#(
   parameter int PMIN_W  = 4,
   parameter int PMAX_W  = 5,
   parameter int LEN_W   = 16,
   parameter bit LEN_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              strip,
   input  logic              rx_dv,
   input  logic [3:0]        rx_nib,
   input  logic [PMIN_W-1:0] pre_min,
   input  logic [PMAX_W-1:0] pre_max,
   input  logic [LEN_W-1:0]  len_min,
   input  logic [LEN_W-1:0]  len_max,
   output logic              fwd,
   output logic              first,
   output logic [ERR_N-1:0]  err_set,
   output logic              eof
);
   localparam int PCNT_W = PMAX_W + 1;
   localparam logic [PCNT_W-1:0] P_ONE = PCNT_W'(1);
   localparam logic [LEN_W-1:0]  L_ONE = LEN_W'(1);

   if (PMAX_W < PMIN_W) begin : g_bad_w
      $error("PMAX_W must not be narrower than PMIN_W");
   end

   trk_st_e           st;
   logic [PCNT_W-1:0] cnt, cnt_inc, pcnt, pmin_x, pmax_x;
   logic [3:0]        prev_nib;
   logic [LEN_W-1:0]  len, len_inc;
   logic              dph, act, sfd_hit;

   assign act     = en && rx_dv;
   assign sfd_hit = (st == ST_PRE) && act && (rx_nib == NIB_SFD) && (prev_nib == NIB_PRE);
   assign cnt_inc = (&cnt) ? cnt : cnt + P_ONE;
   assign pcnt    = cnt - P_ONE;
   assign pmin_x  = PCNT_W'(pre_min);
   assign pmax_x  = PCNT_W'(pre_max);

   if (LEN_SAT) begin : g_len_sat
      assign len_inc = (&len) ? len : len + L_ONE;
   end else begin : g_len_wrap
      assign len_inc = len + L_ONE;
   end

   assign fwd   = strip ? (act && st == ST_DATA) : act;
   assign first = strip ? (sfd_hit || !act) : (!act || st == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         prev_nib <= '0;
         len      <= '0;
         dph      <= 1'b0;
         err_set  <= '0;
         eof      <= 1'b0;
      end else begin
         err_set <= '0;
         eof     <= 1'b0;
         if (!en) begin
            st  <= ST_IDLE;
            cnt <= '0;
            len <= '0;
            dph <= 1'b0;
         end else begin
            unique case (st)
               ST_IDLE: if (rx_dv) begin
                  st       <= ST_PRE;
                  cnt      <= P_ONE;
                  prev_nib <= rx_nib;
               end
               ST_PRE: begin
                  if (!rx_dv) begin
                     st <= ST_IDLE;
                     err_set[ERR_PRE_LONG] <= (cnt > pmax_x);
                  end else if (sfd_hit) begin
                     st  <= ST_DATA;
                     len <= '0;
                     dph <= 1'b0;
                     err_set[ERR_PRE_SHORT] <= (pcnt < pmin_x);
                     err_set[ERR_PRE_LONG]  <= (pcnt > pmax_x);
                  end else begin
                     cnt      <= cnt_inc;
                     prev_nib <= rx_nib;
                  end
               end
               ST_DATA: begin
                  if (!rx_dv) begin
                     st  <= ST_IDLE;
                     eof <= 1'b1;
                     err_set[ERR_FRM_SHORT] <= (len < len_min);
                     err_set[ERR_FRM_LONG]  <= (len > len_max);
                  end else begin
                     dph <= ~dph;
                     if (dph) len <= len_inc;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eof |=> !eof); // R11
   AST_EOF_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> $past(st) == ST_DATA); // R11
endmodule

// File: rtl/mrfg_pack.sv
module mrfg_pack #(
   parameter int NIB_W   = 4,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fwd,
   input  logic               first,
   input  logic [NIB_W-1:0]   nib,
   input  logic               swap,
   output logic [2*NIB_W-1:0] out_byte,
   output logic               out_vld,
   output logic [4*NIB_W-1:0] out_word
);
   localparam int BYTE_W = 2 * NIB_W;

   logic [NIB_W-1:0]  lo_q;
   logic [BYTE_W-1:0] prev_q, byte_nx;
   logic              phase;
   logic              swap_eff;

   if (SWAP_EN) begin : g_swap
      assign swap_eff = swap;
   end else begin : g_fixed
      logic unused_swap;
      assign unused_swap = swap;
      assign swap_eff    = 1'b0;
   end

   assign byte_nx = {nib, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q     <= '0;
         prev_q   <= '0;
         phase    <= 1'b0;
         out_byte <= '0;
         out_vld  <= 1'b0;
         out_word <= '0;
      end else begin
         out_vld <= 1'b0;
         if (fwd) begin
            if (first || !phase) begin
               lo_q  <= nib;
               phase <= 1'b1;
               if (first) prev_q <= '0;
            end else begin
               out_byte <= byte_nx;
               out_vld  <= 1'b1;
               out_word <= swap_eff ? {prev_q, byte_nx} : {byte_nx, prev_q};
               prev_q   <= byte_nx;
               phase    <= 1'b0;
            end
         end else if (first) begin
            phase  <= 1'b0;
            prev_q <= '0;
         end
      end
   end

   AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> !out_vld); // R8
endmodule

// File: rtl/mii_rx_frame_guard.sv
module mii_rx_frame_guard
   import mrfg_pkg::*;
#(
   parameter int DW     = 32,
   parameter int AW     = 2,
   parameter int PMIN_W = 4,
   parameter int PMAX_W = 5,
   parameter int LEN_W  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_dv,
   input  logic [3:0]    rx_nib,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic [7:0]    out_byte,
   output logic          out_byte_vld,
   output logic [15:0]   out_word,
   output logic          out_eof
);
   logic              en, strip, swap, fwd, first;
   logic [PMIN_W-1:0] pre_min;
   logic [PMAX_W-1:0] pre_max;
   logic [LEN_W-1:0]  len_min, len_max;
   logic [ERR_N-1:0]  err_set, err_q;

   mrfg_regs #(.DW(DW), .AW(AW), .PMIN_W(PMIN_W), .PMAX_W(PMAX_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .err_set(err_set), .en(en), .strip(strip), .swap(swap),
      .pre_min(pre_min), .pre_max(pre_max), .len_min(len_min), .len_max(len_max),
      .err_q(err_q));

   mrfg_track #(.PMIN_W(PMIN_W), .PMAX_W(PMAX_W), .LEN_W(LEN_W)) u_track (
      .clk(clk), .rst_n(rst_n), .en(en), .strip(strip), .rx_dv(rx_dv), .rx_nib(rx_nib),
      .pre_min(pre_min), .pre_max(pre_max), .len_min(len_min), .len_max(len_max),
      .fwd(fwd), .first(first), .err_set(err_set), .eof(out_eof));

   mrfg_pack #(.NIB_W(4)) u_pack (
      .clk(clk), .rst_n(rst_n), .fwd(fwd), .first(first), .nib(rx_nib), .swap(swap),
      .out_byte(out_byte), .out_vld(out_byte_vld), .out_word(out_word));

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!out_byte_vld && !out_eof && err_set == '0)); // R12
endmodule

// File: tb/mii_rx_frame_guard_test.sv
`timescale 1ns/1ps
module mii_rx_frame_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_dv = 1'b0;
   logic [3:0]  rx_nib = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0]  out_byte;
   logic        out_byte_vld;
   logic [15:0] out_word;
   logic        out_eof;

   int n_chk = 0;
   int n_fail = 0;
   int n_cap = 0;
   int n_eof = 0;
   logic [7:0] cap [0:63];

   always #2 clk = ~clk;

   mii_rx_frame_guard uut (
      .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_nib(rx_nib), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .out_byte(out_byte), .out_byte_vld(out_byte_vld), .out_word(out_word),
      .out_eof(out_eof));

   always @(negedge clk) begin
      if (out_byte_vld) begin
         if (n_cap < 64) cap[n_cap] <= out_byte;
         n_cap <= n_cap + 1;
      end
      if (out_eof) n_eof <= n_eof + 1;
   end

   // stimulus table: {pre5 count[5:0], data bytes[5:0], strip, expected flags[3:0]}
   localparam int NV = 8;
   localparam logic [16:0] VEC [0:NV-1] = '{
      {6'd15, 6'd6, 1'b0, 4'h0},
      {6'd15, 6'd4, 1'b1, 4'h0},
      {6'd15, 6'd3, 1'b1, 4'h4},
      {6'd15, 6'd8, 1'b1, 4'h0},
      {6'd15, 6'd9, 1'b1, 4'h8},
      {6'd3,  6'd5, 1'b1, 4'h1},
      {6'd16, 6'd5, 1'b1, 4'h2},
      {6'd5,  6'd5, 1'b1, 4'h0}
   };

   function automatic logic [7:0] dbyte(input int k);
      return 8'(8'h10 * k + 8'h03);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic send_frame(input int pre5, input int len, input bit with_sfd);
      @(negedge clk);
      n_cap = 0;
      n_eof = 0;
      for (int i = 0; i < pre5; i++) begin
         rx_dv = 1'b1; rx_nib = 4'h5;
         @(negedge clk);
      end
      if (with_sfd) begin
         rx_nib = 4'hD;
         @(negedge clk);
         for (int k = 0; k < len; k++) begin
            rx_nib = dbyte(k)[3:0];
            @(negedge clk);
            rx_nib = dbyte(k)[7:4];
            @(negedge clk);
         end
      end
      rx_dv = 1'b0; rx_nib = 4'h0;
      repeat (8) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      reg_read(2'd0, rd); check("R1 control", rd, 32'h0);
      reg_read(2'd1, rd); check("R1 preamble limits", rd, 32'h0E1);
      reg_read(2'd2, rd); check("R1 frame limits", rd, 32'h05F1003F);
      reg_read(2'd3, rd); check("R1 flags", rd, 32'h0);

      // R12 disabled: nothing comes out
      send_frame(15, 5, 1'b1);
      check("R12 no bytes when off", n_cap, 0);
      check("R12 no eof when off", n_eof, 0);
      reg_read(2'd3, rd); check("R12 no flags when off", rd, 32'h0);

      // program small frame limits (min 4, max 8), preamble min 4, max 14
      reg_write(2'd2, {16'd8, 16'd4});
      reg_write(2'd1, 32'h0E4);

      // table walk: R2 R3 R4 R6 R8 R9 R11
      for (int v = 0; v < NV; v++) begin
         int   pre5, len, exp_bytes;
         logic strip;
         logic [3:0] exp_flags;
         pre5      = int'(VEC[v][16:11]);
         len       = int'(VEC[v][10:5]);
         strip     = VEC[v][4];
         exp_flags = VEC[v][3:0];
         reg_write(2'd3, 32'hF);
         reg_write(2'd0, {29'd0, 1'b0, strip, 1'b1});
         send_frame(pre5, len, 1'b1);
         exp_bytes = strip ? len : (pre5 + 1) / 2 + len;
         reg_read(2'd3, rd);
         check($sformatf("R2 R3 R4 R6 flags vec %0d", v), rd, {28'd0, exp_flags});
         check($sformatf("R8 R9 byte count vec %0d", v), n_cap, exp_bytes);
         check($sformatf("R11 eof count vec %0d", v), n_eof, 1);
         if (strip) begin
            check($sformatf("R9 first data byte vec %0d", v), {24'd0, cap[0]}, {24'd0, dbyte(0)});
         end else begin
            check("R8 preamble byte", {24'd0, cap[0]}, 32'h55);
            check("R8 delimiter byte", {24'd0, cap[7]}, 32'hD5);
            check("R8 first data byte", {24'd0, cap[8]}, {24'd0, dbyte(0)});
         end
      end

      // R5 long preamble, no delimiter
      reg_write(2'd3, 32'hF);
      send_frame(20, 0, 1'b0);
      reg_read(2'd3, rd); check("R5 long preamble without delimiter", rd, 32'h2);
      check("R11 no eof without delimiter", n_eof, 0);

      // R7 write-one-to-clear: frame with short preamble and short length -> 0x5
      reg_write(2'd3, 32'hF);
      send_frame(3, 2, 1'b1);
      reg_read(2'd3, rd); check("R7 both flags set", rd, 32'h5);
      reg_write(2'd3, 32'h0);
      reg_read(2'd3, rd); check("R7 write 0 keeps flags", rd, 32'h5);
      reg_write(2'd3, 32'h1);
      reg_read(2'd3, rd); check("R7 clear one bit only", rd, 32'h4);

      // R10 word order, normal then swapped
      reg_write(2'd0, 32'h3);
      send_frame(15, 2, 1'b1);
      check("R10 normal word", {16'd0, out_word}, 32'h1303);
      reg_write(2'd0, 32'h7);
      send_frame(15, 2, 1'b1);
      check("R10 swapped word", {16'd0, out_word}, 32'h0313);

      finish_run();
   end
endmodule